// File: doc/BRIEF.md
# External Data Address Steering

This block sits beside an 8-bit CPU and handles its external-data move accesses. For each access it decides whether the access goes to the on-chip data RAM or to the off-chip memory bus. It also works out the full 16-bit address for that access. An access can be one of two kinds. A narrow access carries only a low address byte. A wide access carries a full 16-bit pointer.

Two small registers control the block. Software reaches them through a simple one-cycle write and read port. The page register gives the upper address byte for narrow accesses. The configuration register holds a 2-bit steering mode, which is chosen at run time. It also holds four bus-setup bits that are stored but have no effect inside this block. The mode selects one of four behaviours: everything on-chip, two variants of a 4 KB split between on-chip and off-chip, or everything off-chip. In one of the split variants, a narrow off-chip access takes its upper byte from the high-byte port latch instead of the page register.

The result of an access appears one clock after its strobe. It is a one-cycle select pulse on exactly one of two outputs, together with the resolved address.

Top module: `xdata_steer`

## Requirements
- R1: After reset, the page register reads 0x00 and the configuration register reads 0x03. Register select 0 is the page register and select 1 is the configuration register.
- R2: In mode 10 (configuration bits 3:2), the address of a narrow access is {page, low byte}. It goes on-chip when that address is below 0x1000 and off-chip otherwise.
- R3: In mode 00, every access goes on-chip. The resolved address is the formed address reduced modulo 4096, so it aliases into the on-chip space.
- R4: In mode 01, the on-chip/off-chip decision uses {page, low byte}. A narrow access that goes off-chip takes its upper byte from the port latch instead of the page register.
- R5: The 4 KB boundary is exact: an address of 0x0FFF is on-chip and an address of 0x1000 is off-chip in both split modes.
- R6: In mode 11, every access goes off-chip and the formed address is passed through unaltered.
- R7: A wide access uses its own 16-bit address. It ignores both the page register and the port latch.
- R8: For every access strobe, exactly one of the two selects is high, in the following cycle only. When there is no strobe, neither select is high.
- R9: Configuration bits 7:6 always read as 0, and writes to them are ignored. Bits 5:0 read back as they were written.
- R10: A register write in the same cycle as an access does not affect that access. It takes effect from the next access.
- R11: Whenever the on-chip select is high, the resolved address is below 0x1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write enable |
| regSel | input | 1 | Register select: 0 = page, 1 = configuration |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data of the selected register (combinational) |
| accStrobe | input | 1 | One-cycle access request |
| accWide | input | 1 | 1 = 16-bit pointer access, 0 = 8-bit access |
| accAddr | input | 16 | Access address (only bits 7:0 are used for narrow accesses) |
| portHigh | input | 8 | Current high-byte port latch value |
| onChipSel | output | 1 | On-chip RAM select pulse |
| offChipSel | output | 1 | Off-chip bus select pulse |
| resAddr | output | 16 | Resolved address, held from the last access |

## Verification
Two functions can fall in the same cycle. One is a register write to the page register. The other is an access whose address depends on that register. The bench raises the write enable and the access strobe together on one edge. It then expects the result to be formed from the old page value, and the access that follows to use the new one. The bench also confirms that both selects drop in the cycle after each result, so that back-to-back scenarios cannot hide a stuck pulse.

// File: rtl/xdata_steer_pkg.sv
package xdata_steer_pkg;

  typedef enum logic [1:0] {
    MODE_INT         = 2'b00,
    MODE_SPLIT_LATCH = 2'b01,
    MODE_SPLIT_PAGE  = 2'b10,
    MODE_EXT         = 2'b11
  } steerMode_e;

  typedef struct packed {
    logic       fire;
    logic       wide;
    steerMode_e mode;
  } steerCmd_t;

  localparam int CFG_KEEP_W = 6;
  localparam logic [CFG_KEEP_W-1:0] CFG_RESET = 6'h03;

endpackage

// File: rtl/xdata_steer_ctrl.sv
module xdata_steer_ctrl
  import xdata_steer_pkg::*;
#(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [PAGE_W-1:0] regWrData,
  output logic [PAGE_W-1:0] regRdData,
  input  logic              accStrobe,
  input  logic              accWide,
  output logic [PAGE_W-1:0] pageSel,
  output steerMode_e        cfgMode,
  output steerCmd_t         cmd
);

  localparam int PAD_W = PAGE_W - CFG_KEEP_W;

  logic [CFG_KEEP_W-1:0] cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageSel <= '0;
      cfgReg  <= CFG_RESET;
    end else if (regWrEn) begin
      if (regSel) cfgReg  <= regWrData[CFG_KEEP_W-1:0];
      else        pageSel <= regWrData;
    end
  end

  assign cfgMode = steerMode_e'(cfgReg[3:2]);

  always_comb begin
    if (regSel) regRdData = {{PAD_W{1'b0}}, cfgReg};
    else        regRdData = pageSel;
  end

  always_comb begin
    cmd.fire = accStrobe;
    cmd.wide = accWide;
    cmd.mode = cfgMode;
  end

endmodule

// File: rtl/xdata_steer_path.sv
module xdata_steer_path
  import xdata_steer_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LOW_W     = 8,
  parameter int ONCHIP_AW = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  steerCmd_t               cmd,
  input  logic [ADDR_W-1:0]       accAddr,
  input  logic [ADDR_W-LOW_W-1:0] pageSel,
  input  logic [ADDR_W-LOW_W-1:0] portHigh,
  output logic                    onChipSel,
  output logic                    offChipSel,
  output logic [ADDR_W-1:0]       resAddr
);

  localparam int HI_W   = ADDR_W - LOW_W;
  localparam int FOLD_W = ADDR_W - ONCHIP_AW;

  logic [ADDR_W-1:0] formAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic              belowBound;
  logic              toOnChip;

  assign formAddr   = cmd.wide ? accAddr : {pageSel, accAddr[LOW_W-1:0]};
  assign belowBound = (formAddr[ADDR_W-1:ONCHIP_AW] == '0);

  always_comb begin
    toOnChip = 1'b0;
    nextAddr = formAddr;
    unique case (cmd.mode)
      MODE_INT: begin
        toOnChip = 1'b1;
        nextAddr = {{FOLD_W{1'b0}}, formAddr[ONCHIP_AW-1:0]};
      end
      MODE_SPLIT_LATCH: begin
        toOnChip = belowBound;
        if (!belowBound && !cmd.wide)
          nextAddr = {portHigh[HI_W-1:0], formAddr[LOW_W-1:0]};
      end
      MODE_SPLIT_PAGE: toOnChip = belowBound;
      MODE_EXT:        toOnChip = 1'b0;
      default:         toOnChip = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onChipSel  <= 1'b0;
      offChipSel <= 1'b0;
      resAddr    <= '0;
    end else begin
      onChipSel  <= cmd.fire & toOnChip;
      offChipSel <= cmd.fire & ~toOnChip;
      if (cmd.fire) resAddr <= nextAddr;
    end
  end

endmodule

// File: rtl/xdata_steer.sv
module xdata_steer
  import xdata_steer_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LOW_W     = 8,
  parameter int ONCHIP_AW = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic                    regSel,
  input  logic [ADDR_W-LOW_W-1:0] regWrData,
  output logic [ADDR_W-LOW_W-1:0] regRdData,
  input  logic                    accStrobe,
  input  logic                    accWide,
  input  logic [ADDR_W-1:0]       accAddr,
  input  logic [ADDR_W-LOW_W-1:0] portHigh,
  output logic                    onChipSel,
  output logic                    offChipSel,
  output logic [ADDR_W-1:0]       resAddr
);

  localparam int PAGE_W = ADDR_W - LOW_W;

  logic [PAGE_W-1:0] pageSel;
  steerMode_e        cfgMode;
  steerCmd_t         cmd;

  xdata_steer_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .accStrobe (accStrobe),
    .accWide   (accWide),
    .pageSel   (pageSel),
    .cfgMode   (cfgMode),
    .cmd       (cmd)
  );

  xdata_steer_path #(
    .ADDR_W    (ADDR_W),
    .LOW_W     (LOW_W),
    .ONCHIP_AW (ONCHIP_AW)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .accAddr    (accAddr),
    .pageSel    (pageSel),
    .portHigh   (portHigh),
    .onChipSel  (onChipSel),
    .offChipSel (offChipSel),
    .resAddr    (resAddr)
  );

endmodule

// File: rtl/xdata_steer_chk.sv
module xdata_steer_chk
  import xdata_steer_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LOW_W     = 8,
  parameter int ONCHIP_AW = 12
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    regSel,
  input logic [ADDR_W-LOW_W-1:0] regRdData,
  input logic                    accStrobe,
  input logic                    accWide,
  input logic [ADDR_W-1:0]       accAddr,
  input steerMode_e              cfgMode,
  input logic                    onChipSel,
  input logic                    offChipSel,
  input logic [ADDR_W-1:0]       resAddr
);

  assert_one_sel_R8: assert property (@(posedge clk) disable iff (!rstN)
    accStrobe |=> ($countones({onChipSel, offChipSel}) == 1));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !accStrobe |=> (!onChipSel && !offChipSel));

  assert_onchip_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    onChipSel |-> (resAddr[ADDR_W-1:ONCHIP_AW] == '0));

  assert_int_mode_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && cfgMode == MODE_INT) |=> onChipSel);

  assert_ext_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && cfgMode == MODE_EXT) |=> offChipSel);

  assert_wide_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && accWide && cfgMode != MODE_INT) |=> (resAddr == $past(accAddr)));

  assert_cfg_top_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    regSel |-> (regRdData[ADDR_W-LOW_W-1:ADDR_W-LOW_W-2] == 2'b00));

endmodule

bind xdata_steer xdata_steer_chk #(
  .ADDR_W    (ADDR_W),
  .LOW_W     (LOW_W),
  .ONCHIP_AW (ONCHIP_AW)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regSel     (regSel),
  .regRdData  (regRdData),
  .accStrobe  (accStrobe),
  .accWide    (accWide),
  .accAddr    (accAddr),
  .cfgMode    (cfgMode),
  .onChipSel  (onChipSel),
  .offChipSel (offChipSel),
  .resAddr    (resAddr)
);

// File: tb/xdata_steer_tb.sv
module xdata_steer_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        accStrobe = 1'b0;
  logic        accWide = 1'b0;
  logic [15:0] accAddr = '0;
  logic [7:0]  portHigh = '0;
  logic        onChipSel;
  logic        offChipSel;
  logic [15:0] resAddr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xdata_steer u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .accStrobe(accStrobe),
    .accWide(accWide), .accAddr(accAddr), .portHigh(portHigh),
    .onChipSel(onChipSel), .offChipSel(offChipSel), .resAddr(resAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic sel, output logic [7:0] data);
    @(negedge clk);
    regSel = sel;
    #1 data = regRdData;
  endtask

  // one access; expects onChip (1) or offChip (0) and the address
  task automatic access(input string req, input logic wide, input logic [15:0] addr,
                        input logic [7:0] port, input logic expOn, input logic [15:0] expAddr);
    @(negedge clk);
    accStrobe = 1'b1; accWide = wide; accAddr = addr; portHigh = port;
    @(negedge clk);
    accStrobe = 1'b0;
    check(req, {onChipSel, offChipSel}, {expOn, ~expOn});
    check(req, resAddr, expAddr);
    @(negedge clk);
    check("R8", {onChipSel, offChipSel}, 2'b00);
  endtask

  task automatic testReset();
    logic [7:0] v;
    readReg(1'b0, v); check("R1", v, 8'h00);
    readReg(1'b1, v); check("R1", v, 8'h03);
    check("R8", {onChipSel, offChipSel}, 2'b00);
  endtask

  task automatic testIntMode();
    writeReg(1'b1, 8'h03);
    writeReg(1'b0, 8'h35);
    access("R3", 1'b0, 16'h007A, 8'h9E, 1'b1, 16'h057A);
    access("R3", 1'b1, 16'hABCD, 8'h9E, 1'b1, 16'h0BCD);
  endtask

  task automatic testLatchMode();
    writeReg(1'b1, 8'h07);
    writeReg(1'b0, 8'h0C);
    access("R4", 1'b0, 16'h0044, 8'h9E, 1'b1, 16'h0C44);
    writeReg(1'b0, 8'h20);
    access("R4", 1'b0, 16'h0044, 8'h9E, 1'b0, 16'h9E44);
    writeReg(1'b0, 8'h10);
    access("R5", 1'b0, 16'h0000, 8'h71, 1'b0, 16'h7100);
    writeReg(1'b0, 8'h0F);
    access("R5", 1'b0, 16'h00FF, 8'h71, 1'b1, 16'h0FFF);
    access("R7", 1'b1, 16'h5A5A, 8'h71, 1'b0, 16'h5A5A);
  endtask

  task automatic testPageMode();
    writeReg(1'b1, 8'h0B);
    writeReg(1'b0, 8'h20);
    access("R2", 1'b0, 16'h0044, 8'h9E, 1'b0, 16'h2044);
    writeReg(1'b0, 8'h0F);
    access("R2", 1'b0, 16'h0044, 8'h9E, 1'b1, 16'h0F44);
    access("R5", 1'b1, 16'h1000, 8'h9E, 1'b0, 16'h1000);
    access("R5", 1'b1, 16'h0FFF, 8'h9E, 1'b1, 16'h0FFF);
    writeReg(1'b0, 8'hEE);
    access("R7", 1'b1, 16'h0123, 8'hDD, 1'b1, 16'h0123);
  endtask

  task automatic testExtMode();
    writeReg(1'b1, 8'h0F);
    writeReg(1'b0, 8'h03);
    access("R6", 1'b0, 16'h0011, 8'h9E, 1'b0, 16'h0311);
    access("R6", 1'b1, 16'h0042, 8'h9E, 1'b0, 16'h0042);
  endtask

  task automatic testCfgTopBits();
    logic [7:0] v;
    writeReg(1'b1, 8'hFF);
    readReg(1'b1, v); check("R9", v, 8'h3F);
    writeReg(1'b1, 8'hC3);
    readReg(1'b1, v); check("R9", v, 8'h03);
    writeReg(1'b0, 8'h45);
    access("R9", 1'b0, 16'h0001, 8'h00, 1'b1, 16'h0501);
  endtask

  task automatic testSameCycleWrite();
    writeReg(1'b1, 8'h0B);
    writeReg(1'b0, 8'h20);
    @(negedge clk);
    regWrEn = 1'b1; regSel = 1'b0; regWrData = 8'h05;
    accStrobe = 1'b1; accWide = 1'b0; accAddr = 16'h0010; portHigh = 8'h00;
    @(negedge clk);
    regWrEn = 1'b0; accStrobe = 1'b0;
    check("R10", {onChipSel, offChipSel}, 2'b01);
    check("R10", resAddr, 16'h2010);
    access("R10", 1'b0, 16'h0010, 8'h00, 1'b1, 16'h0510);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIntMode();
    testLatchMode();
    testPageMode();
    testExtMode();
    testCfgTopBits();
    testSameCycleWrite();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule